// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block drives the chip-select lines of an SPI master. A 32-bit control word picks one target line, chooses between automatic and manual control, and fixes the polarity. In automatic mode the picked line goes to its active level while the shift engine reports busy, and returns to idle when the engine stops. In manual mode software sets the picked line's level directly, whatever the engine is doing.

The polarity bit does two things. It sets which level counts as active for the picked line. It also sets the idle level of every line that is not picked, and it does this in manual mode too. As a result, lines for devices with active-low selects idle high only while the bit is set.

Every output comes from a flop clocked by the block clock. An input change shows on the pins at the next rising edge and never as a combinational glitch. Set-up and hold delays between chip select and the serial clock are the shift engine's job.

Top module: `spi_cs_ctrl`

## Requirements
- R1: While rst_ni is low, every line of cs_o is driven high, whatever the control word holds.
- R2: Automatic mode (control bit 16 = 0), busy_i = 1: the line whose index is in control bits 13:12 drives the active level, which is low when control bit 4 = 1 and high when it is 0.
- R3: Automatic mode, busy_i = 0: the indexed line drives the inactive level, which equals control bit 4.
- R4: Manual mode (control bit 16 = 1): the indexed line drives the value of control bit 17, and busy_i has no effect on it.
- R5: Every line other than the indexed one drives the value of control bit 4 in both modes.
- R6: The index value n in control bits 13:12 (0 to 3) acts on cs_o[n] only. At most one line differs from the idle level at any time.
- R7: cs_o changes only at a rising clock edge. An input change shows one edge later, not before.
- R8: Control bits other than 4, 12, 13, 16 and 17 have no effect on cs_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: index [13:12], manual enable [16], manual level [17], active-low [4] |
| busy_i | input | 1 | Shift engine is running a burst |
| cs_o | output | 4 | Registered chip-select lines |

## Verification
The automatic path is tried with each of the four index values, with busy both high and low, and under both polarities. This separates a mis-decoded index from a mis-applied polarity. Manual mode is tried with the level bit set against busy in both directions, which shows whether busy leaks through in manual mode. It is also tried with the polarity cleared, which exposes a design that uses the manual level to set the lines that are not picked. A control word with every unrelated bit set catches decoding of the wrong field positions. An input change is sampled half a cycle before its edge to confirm that the outputs are registered.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int CTRL_W          = 32;
  localparam int CS_POL_BIT      = 4;
  localparam int CS_IDX_LSB      = 12;
  localparam int CS_IDX_W        = 2;
  localparam int CS_MAN_EN_BIT   = 16;
  localparam int CS_MAN_LVL_BIT  = 17;

  typedef struct packed {
    logic man_en;
    logic man_lvl;
    logic act_low;
  } cs_mode_t;
endpackage

// File: rtl/spi_cs_decode.sv
module spi_cs_decode
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output cs_mode_t          mode_o,
  output logic [NUM_CS-1:0] hit_o
);
  logic [IDX_W-1:0] idx;
  logic             unused_ctrl;

  assign idx            = ctrl_i[CS_IDX_LSB +: IDX_W];
  assign mode_o.man_en  = ctrl_i[CS_MAN_EN_BIT];
  assign mode_o.man_lvl = ctrl_i[CS_MAN_LVL_BIT];
  assign mode_o.act_low = ctrl_i[CS_POL_BIT];
  assign unused_ctrl    = ^ctrl_i;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_hit
    assign hit_o[g] = (idx == IDX_W'(g));
  end
endmodule

// File: rtl/spi_cs_line.sv
module spi_cs_line
  import spi_cs_pkg::*;
#(
  parameter logic RST_LVL = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hit_i,
  input  cs_mode_t mode_i,
  input  logic     busy_i,
  output logic     cs_o
);
  logic lvl_d;
  logic armed_q;

  always_comb begin
    lvl_d = mode_i.act_low;
    if (hit_i) begin
      if (mode_i.man_en) lvl_d = mode_i.man_lvl;
      else if (busy_i)   lvl_d = ~mode_i.act_low;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o    <= RST_LVL;
      armed_q <= 1'b0;
    end else begin
      cs_o    <= lvl_d;
      armed_q <= 1'b1;
    end
  end

  // R5: unselected line idles at polarity bit
  a_r5_unsel_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(!hit_i) |-> cs_o == $past(mode_i.act_low));

  // R4: manual level wins over busy
  a_r4_manual_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(hit_i && mode_i.man_en) |-> cs_o == $past(mode_i.man_lvl));

  // R2
  a_r2_auto_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(hit_i && !mode_i.man_en && busy_i) |-> cs_o != $past(mode_i.act_low));

  // R3
  a_r3_auto_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $past(hit_i && !mode_i.man_en && !busy_i) |-> cs_o == $past(mode_i.act_low));
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              busy_i,
  output logic [NUM_CS-1:0] cs_o
);
  cs_mode_t          mode;
  logic [NUM_CS-1:0] hit;
  logic              armed_q;

  spi_cs_decode #(.NUM_CS(NUM_CS)) u_decode (
    .ctrl_i (ctrl_i),
    .mode_o (mode),
    .hit_o  (hit)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    spi_cs_line #(.RST_LVL(1'b1)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hit_i  (hit[g]),
      .mode_i (mode),
      .busy_i (busy_i),
      .cs_o   (cs_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R6: at most one line away from idle
  a_r6_single_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> $countones(cs_o ^ {NUM_CS{$past(mode.act_low)}}) <= 1);

  // R7: outputs hold when inputs were held
  a_r7_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && $stable(ctrl_i) && $stable(busy_i) && $past(armed_q) |=> $stable(cs_o));
endmodule

// File: tb/spi_cs_ctrl_tb_top.sv
module spi_cs_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic        busy_i = 1'b0;
  logic [3:0]  cs_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  spi_cs_ctrl dut_i (.clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
                     .busy_i(busy_i), .cs_o(cs_o));

  function automatic logic [31:0] mk(int idx, bit man, bit lvl, bit al);
    logic [31:0] w = '0;
    w[13:12] = 2'(idx);
    w[16] = man;
    w[17] = lvl;
    w[4] = al;
    return w;
  endfunction

  function automatic logic [3:0] model(logic [31:0] w, logic b);
    logic [3:0] r = {4{w[4]}};
    int i = int'(w[13:12]);
    if (w[16]) r[i] = w[17];
    else if (b) r[i] = ~w[4];
    return r;
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    n_chk++;
    if (cs_o !== exp) begin
      n_fail++;
      $display("FAIL %s: cs_o=%b expected %b", req, cs_o, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic b, string req);
    @(negedge clk_i);
    ctrl_i = w;
    busy_i = b;
    @(posedge clk_i);
    #1;
    chk(req, model(w, b));
  endtask

  task automatic t_reset();
    ctrl_i = mk(2, 1'b1, 1'b0, 1'b0);
    busy_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1 chk("R1", 4'hF);
    @(negedge clk_i) rst_ni = 1'b1;
    apply(mk(0, 1'b0, 1'b0, 1'b1), 1'b0, "R3");
  endtask

  task automatic t_auto();
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 4; i++) begin
        apply(mk(i, 1'b0, 1'b0, p[0]), 1'b1, "R2/R6");
        apply(mk(i, 1'b0, 1'b0, p[0]), 1'b0, "R3");
      end
  endtask

  task automatic t_manual();
    apply(mk(1, 1'b1, 1'b0, 1'b1), 1'b0, "R4");
    apply(mk(1, 1'b1, 1'b1, 1'b1), 1'b1, "R4");
    apply(mk(3, 1'b1, 1'b0, 1'b1), 1'b1, "R4");
    apply(mk(2, 1'b1, 1'b1, 1'b0), 1'b0, "R5");
    apply(mk(2, 1'b1, 1'b0, 1'b0), 1'b1, "R5");
    apply(mk(0, 1'b1, 1'b1, 1'b0), 1'b0, "R5");
  endtask

  task automatic t_noise();
    logic [31:0] noise = 32'hFFFC_CFEF;
    apply(noise | mk(2, 1'b0, 1'b0, 1'b1), 1'b1, "R8");
    apply(noise | mk(1, 1'b0, 1'b0, 1'b0), 1'b1, "R8");
    apply(noise | mk(3, 1'b0, 1'b0, 1'b1), 1'b0, "R8");
  endtask

  task automatic t_timing();
    logic [3:0] prev;
    apply(mk(0, 1'b0, 1'b0, 1'b1), 1'b0, "R7");
    prev = cs_o;
    @(negedge clk_i);
    ctrl_i = mk(3, 1'b0, 1'b0, 1'b1);
    busy_i = 1'b1;
    #1 chk("R7", prev);
    @(posedge clk_i);
    #1 chk("R7", 4'b0111);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_auto();
        t_manual();
        t_noise();
        t_timing();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule